// File: doc/BRIEF.md
# CCD Frame Readout Sequencer

This block steps an interline CCD with a charge-multiplying horizontal path through one complete frame. A single start strobe launches the sequence. The block clears the photodiodes with an electronic shutter pulse and then waits out the integration time. Next it moves the photodiode charge into the vertical register. After that, for every row, it performs a vertical shift followed by a horizontal line burst. It raises a one-cycle completion pulse after the last line. Each step lasts a programmed number of clock ticks.

The outputs are logic-level enables intended for a downstream clock-waveform generator. These cover the shutter, the vertical first-phase third level, the vertical row shift, the horizontal run/park state and parked phase levels, the multiplier-clock enable, the analog front end black-level clamp window and a per-line reset-gate low pulse. Whenever the horizontal register is not running, it is parked with phase 1 high and phase 2 low. In high-rate bypass mode the multiplier clocks stay disabled.

Timing limits scale with the parameter `UNIT_TICKS`, which is the number of clock ticks in one time unit. The defaults used below are `UNIT_TICKS` = 10 and `CLAMP_CYC` = 28. All programmed values are captured when start is accepted.

Top module: `ccd_frame_seq`

## Requirements
- R1: The shutter output is high for exactly the programmed shutter tick count, clamped to the range [2*UNIT_TICKS, 10*UNIT_TICKS] (20..100 ticks by default). It rises on the cycle after start is accepted.
- R2: While the shutter output is high, both the horizontal run output and the multiplier enable output are low.
- R3: Integration begins on the first cycle after the shutter output falls. The vertical third-level output rises exactly max(integration ticks, 1) cycles later.
- R4: The vertical third-level output is high for the transfer tick count clamped to [1, 5*UNIT_TICKS]. The first row shift starts on the cycle after it falls.
- R5: Each row shift holds the vertical shift output high for the row tick count clamped to [ceil-free 12*UNIT_TICKS/10, 4*UNIT_TICKS] (12..40 by default). The horizontal run output is low during every row shift.
- R6: Each row shift is followed by one line burst during which the horizontal run output is high for max(pixel count, 1) cycles. The frame contains max(row count, 1) bursts. During a burst the two phase outputs are always complementary. When the horizontal run output is low, phase 1 is 1 and phase 2 is 0.
- R7: The clamp output is high only during the first min(CLAMP_CYC, line length) cycles of every line burst, in both modes.
- R8: The reset-gate low output pulses for exactly one cycle, the first cycle of every line burst, in both modes.
- R9: With bypass low at start, the multiplier enable output equals the horizontal run output. With bypass high at start, it stays low for the whole frame.
- R10: The done output is a one-cycle pulse on the cycle after the last cycle of the final line burst. The busy output is high from the shutter's first cycle through the done cycle.
- R11: The asynchronous reset drives every enable low with the horizontal register parked. A start strobe during a frame is ignored. Changes to the configuration inputs during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe, accepted only when idle |
| bypass_i | input | 1 | High-rate bypass: multiplier clocks disabled |
| shut_ticks_i | input | 16 | Shutter pulse width in ticks |
| integ_ticks_i | input | 16 | Integration time in ticks |
| xfer_ticks_i | input | 16 | Photodiode-to-vertical transfer time in ticks |
| rowt_ticks_i | input | 16 | Vertical row shift time in ticks |
| rows_i | input | 12 | Rows per frame |
| pixels_i | input | 12 | Horizontal cycles per line |
| shutter_o | output | 1 | Electronic shutter enable |
| v1_high_o | output | 1 | Vertical phase 1 third-level enable |
| vshift_o | output | 1 | Vertical row shift enable |
| h_run_o | output | 1 | Horizontal register running |
| h1_o | output | 1 | Horizontal phase 1 level |
| h2_o | output | 1 | Horizontal phase 2 level |
| mult_en_o | output | 1 | Multiplier clock enable |
| clamp_o | output | 1 | Front-end black-level clamp window |
| rg_low_o | output | 1 | Reset-gate low pulse |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete pulse |

## Verification
The properties assume that the start strobe is synchronous to `clk_i`. They also assume that the tick-count inputs hold their values from the cycle before start until start is accepted, because capture happens on that edge. The shutter-width property relies on the clamp to keep every accepted frame within the legal window, whatever value is driven. The stimulus changes configuration inputs and pulses start only at the falling clock edge. It deliberately drives out-of-range, zero and exactly-at-limit values so that the clamps are exercised without any property being weakened.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHUT,
    ST_INTEG,
    ST_XFER,
    ST_ROW,
    ST_LINE,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/ccd_dur_limit.sv
module ccd_dur_limit #(
  parameter int W = 16,
  parameter logic [W-1:0] LO = 1,
  parameter logic [W-1:0] HI = {W{1'b1}}
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);

  always_comb begin
    if (val_i < LO)      val_o = LO;
    else if (val_i > HI) val_o = HI;
    else                 val_o = val_i;
  end

endmodule

// File: rtl/ccd_tick_timer.sv
module ccd_tick_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/ccd_line_gen.sv
module ccd_line_gen #(
  parameter int W         = 16,
  parameter int CLAMP_CYC = 28
) (
  input  logic         run_i,
  input  logic         byp_i,
  input  logic [W-1:0] pos_i,
  output logic         h1_o,
  output logic         h2_o,
  output logic         mult_en_o,
  output logic         clamp_o,
  output logic         rg_low_o
);

  // parked: phase 1 high, phase 2 low
  assign h1_o      = run_i ? pos_i[0]  : 1'b1;
  assign h2_o      = run_i ? ~pos_i[0] : 1'b0;
  assign mult_en_o = run_i & ~byp_i;
  assign clamp_o   = run_i && (pos_i < W'(CLAMP_CYC));
  assign rg_low_o  = run_i && (pos_i == '0);

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_seq_pkg::*;
#(
  parameter int UNIT_TICKS = 10,
  parameter int DUR_W      = 16,
  parameter int ROW_W      = 12,
  parameter int PIX_W      = 12,
  parameter int CLAMP_CYC  = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bypass_i,
  input  logic [DUR_W-1:0] shut_ticks_i,
  input  logic [DUR_W-1:0] integ_ticks_i,
  input  logic [DUR_W-1:0] xfer_ticks_i,
  input  logic [DUR_W-1:0] rowt_ticks_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [PIX_W-1:0] pixels_i,
  output logic             shutter_o,
  output logic             v1_high_o,
  output logic             vshift_o,
  output logic             h_run_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             mult_en_o,
  output logic             clamp_o,
  output logic             rg_low_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int SHUT_MIN = 2 * UNIT_TICKS;
  localparam int SHUT_MAX = 10 * UNIT_TICKS;
  localparam int XFER_MAX = 5 * UNIT_TICKS;
  localparam int ROWT_MIN = (12 * UNIT_TICKS) / 10;
  localparam int ROWT_MAX = 4 * UNIT_TICKS;
  localparam int CNT_W    = (DUR_W > PIX_W) ? DUR_W : PIX_W;

  seq_state_e state_q, state_d;

  logic [DUR_W-1:0] shut_lim, integ_lim, xfer_lim, rowt_lim;
  logic [ROW_W-1:0] rows_lim;
  logic [PIX_W-1:0] pix_lim;

  logic [DUR_W-1:0] shut_q, integ_q, xfer_q, rowt_q;
  logic [ROW_W-1:0] rows_q, row_idx_q;
  logic [PIX_W-1:0] pix_q;
  logic             byp_q;

  logic [CNT_W-1:0] cnt, len;
  logic             last, clr, accept;

  ccd_dur_limit #(.W(DUR_W), .LO(DUR_W'(SHUT_MIN)), .HI(DUR_W'(SHUT_MAX)))
    u_lim_shut (.val_i(shut_ticks_i), .val_o(shut_lim));
  ccd_dur_limit #(.W(DUR_W), .LO(DUR_W'(1)), .HI({DUR_W{1'b1}}))
    u_lim_integ (.val_i(integ_ticks_i), .val_o(integ_lim));
  ccd_dur_limit #(.W(DUR_W), .LO(DUR_W'(1)), .HI(DUR_W'(XFER_MAX)))
    u_lim_xfer (.val_i(xfer_ticks_i), .val_o(xfer_lim));
  ccd_dur_limit #(.W(DUR_W), .LO(DUR_W'(ROWT_MIN)), .HI(DUR_W'(ROWT_MAX)))
    u_lim_rowt (.val_i(rowt_ticks_i), .val_o(rowt_lim));
  ccd_dur_limit #(.W(ROW_W), .LO(ROW_W'(1)), .HI({ROW_W{1'b1}}))
    u_lim_rows (.val_i(rows_i), .val_o(rows_lim));
  ccd_dur_limit #(.W(PIX_W), .LO(PIX_W'(1)), .HI({PIX_W{1'b1}}))
    u_lim_pix (.val_i(pixels_i), .val_o(pix_lim));

  assign accept = (state_q == ST_IDLE) && start_i;

  // config captured once per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_q  <= DUR_W'(SHUT_MIN);
      integ_q <= DUR_W'(1);
      xfer_q  <= DUR_W'(1);
      rowt_q  <= DUR_W'(ROWT_MIN);
      rows_q  <= ROW_W'(1);
      pix_q   <= PIX_W'(1);
      byp_q   <= 1'b0;
    end else if (accept) begin
      shut_q  <= shut_lim;
      integ_q <= integ_lim;
      xfer_q  <= xfer_lim;
      rowt_q  <= rowt_lim;
      rows_q  <= rows_lim;
      pix_q   <= pix_lim;
      byp_q   <= bypass_i;
    end
  end

  always_comb begin
    len = CNT_W'(1);
    unique case (state_q)
      ST_SHUT:  len = CNT_W'(shut_q);
      ST_INTEG: len = CNT_W'(integ_q);
      ST_XFER:  len = CNT_W'(xfer_q);
      ST_ROW:   len = CNT_W'(rowt_q);
      ST_LINE:  len = CNT_W'(pix_q);
      default:  len = CNT_W'(1);
    endcase
  end

  assign last = (cnt == len - 1'b1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SHUT;
      ST_SHUT:  if (last) state_d = ST_INTEG;
      ST_INTEG: if (last) state_d = ST_XFER;
      ST_XFER:  if (last) state_d = ST_ROW;
      ST_ROW:   if (last) state_d = ST_LINE;
      ST_LINE:  if (last) state_d = (row_idx_q == rows_q - 1'b1) ? ST_DONE : ST_ROW;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // every step and every line restarts the tick count
  assign clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      row_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_XFER)                row_idx_q <= '0;
      else if (state_q == ST_LINE && last)   row_idx_q <= row_idx_q + 1'b1;
    end
  end

  ccd_tick_timer #(.W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .cnt_o (cnt)
  );

  assign h_run_o = (state_q == ST_LINE);

  ccd_line_gen #(.W(CNT_W), .CLAMP_CYC(CLAMP_CYC)) u_line (
    .run_i    (h_run_o),
    .byp_i    (byp_q),
    .pos_i    (cnt),
    .h1_o     (h1_o),
    .h2_o     (h2_o),
    .mult_en_o(mult_en_o),
    .clamp_o  (clamp_o),
    .rg_low_o (rg_low_o)
  );

  assign shutter_o = (state_q == ST_SHUT);
  assign v1_high_o = (state_q == ST_XFER);
  assign vshift_o  = (state_q == ST_ROW);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk #(
  parameter int UNIT_TICKS = 10,
  parameter int CLAMP_CYC  = 28
) (
  input logic clk_i,
  input logic rst_ni,
  input logic shutter_o,
  input logic v1_high_o,
  input logic vshift_o,
  input logic h_run_o,
  input logic h1_o,
  input logic h2_o,
  input logic mult_en_o,
  input logic clamp_o,
  input logic rg_low_o,
  input logic busy_o,
  input logic done_o
);

  localparam int SHUT_MIN = 2 * UNIT_TICKS;
  localparam int SHUT_MAX = 10 * UNIT_TICKS;

  logic [15:0] shut_len, line_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_len <= '0;
      line_pos <= '0;
    end else begin
      shut_len <= shutter_o ? shut_len + 1'b1 : '0;
      line_pos <= h_run_o ? line_pos + 1'b1 : '0;
    end
  end

  p_shut_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutter_o && shut_len != 0) |-> (shut_len >= 16'(SHUT_MIN) && shut_len <= 16'(SHUT_MAX)));

  p_h_stop_shut_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutter_o |-> (!h_run_o && !mult_en_o));

  p_integ_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutter_o && shut_len != 0) |-> !v1_high_o);

  p_vshift_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vshift_o |-> (!h_run_o && !v1_high_o));

  p_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_run_o |-> (h1_o && !h2_o));

  p_phase_comp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_run_o |-> (h1_o != h2_o));

  p_clamp_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (h_run_o && line_pos < 16'(CLAMP_CYC)));

  p_rg_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_low_o |-> (h_run_o && line_pos == 0));

  p_mult_in_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_en_o |-> h_run_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

endmodule

bind ccd_frame_seq ccd_frame_seq_chk #(.UNIT_TICKS(UNIT_TICKS), .CLAMP_CYC(CLAMP_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .shutter_o(shutter_o),
  .v1_high_o(v1_high_o),
  .vshift_o (vshift_o),
  .h_run_o  (h_run_o),
  .h1_o     (h1_o),
  .h2_o     (h2_o),
  .mult_en_o(mult_en_o),
  .clamp_o  (clamp_o),
  .rg_low_o (rg_low_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sim_ccd_frame_seq.sv
`timescale 1ns/1ps
module sim_ccd_frame_seq;

  typedef struct packed {
    int shut; int integ; int xfer; int rowt; int rows; int pix; int byp;
    int exp_shut; int exp_lines;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{25,  5, 30, 15, 3, 40, 0,  25, 3},
    '{ 5,  0,  0,  3, 2, 10, 1,  20, 2},
    '{500, 3, 99, 77, 0,  0, 0, 100, 1},
    '{20,  2, 50, 12, 4, 28, 1,  20, 4},
    '{100, 1,  1, 40, 2, 29, 0, 100, 2}
  };

  logic clk = 0, rst_n = 0, start = 0, byp = 0;
  logic [15:0] shut_t = 0, integ_t = 0, xfer_t = 0, rowt_t = 0;
  logic [11:0] rows = 0, pix = 0;
  logic shutter, v1, vshift, h_run, h1, h2, mult, clamp, rg, busy, done;

  always #4 clk = ~clk;

  ccd_frame_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bypass_i(byp),
    .shut_ticks_i(shut_t), .integ_ticks_i(integ_t), .xfer_ticks_i(xfer_t),
    .rowt_ticks_i(rowt_t), .rows_i(rows), .pixels_i(pix),
    .shutter_o(shutter), .v1_high_o(v1), .vshift_o(vshift), .h_run_o(h_run),
    .h1_o(h1), .h2_o(h2), .mult_en_o(mult), .clamp_o(clamp), .rg_low_o(rg),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0, errors = 0;
  int cyc, n_shut, shut_fall, v1_first, n_v1, vs_first, n_vs, n_lines, n_h, last_h;
  int pos, n_clamp, n_rg, n_mult, n_done, done_at, viol, busy_low;
  bit prev_shut, prev_v1, prev_h, vs_seen, framed;

  task automatic clear_mon();
    cyc = 0; n_shut = 0; shut_fall = -1; v1_first = -1; n_v1 = 0; vs_first = -1; n_vs = 0;
    n_lines = 0; n_h = 0; last_h = -1; pos = 0; n_clamp = 0; n_rg = 0; n_mult = 0;
    n_done = 0; done_at = -1; viol = 0; busy_low = 0; vs_seen = 0; framed = 0;
    prev_shut = 0; prev_v1 = 0; prev_h = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (shutter) begin n_shut++; framed = 1; end
    if (prev_shut && !shutter) shut_fall = cyc;
    if (v1 && !prev_v1) v1_first = cyc;
    if (v1) n_v1++;
    if (vshift && !vs_seen) begin vs_first = cyc; vs_seen = 1; end
    if (vshift) n_vs++;
    if (h_run) begin
      if (!prev_h) n_lines++;
      pos = prev_h ? pos + 1 : 0;
      n_h++; last_h = cyc;
    end
    if (clamp) begin n_clamp++; if (!h_run || pos >= 28) viol++; end
    if (rg) begin n_rg++; if (!h_run || pos != 0) viol++; end
    if (mult) n_mult++;
    if (done) begin n_done++; done_at = cyc; end
    if ((shutter || vshift) && (h_run || mult)) viol++;
    if (!h_run && !(h1 && !h2)) viol++;
    if (h_run && h1 == h2) viol++;
    if (framed && !done && n_done == 0 && !busy) busy_low++;
    prev_shut = shutter; prev_v1 = v1; prev_h = h_run;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic run_frame(input vec_t v, input bit mid_start, input bit mid_cfg);
    int t;
    int e_integ, e_xfer, e_rowt, e_rows, e_pix, e_clamp;
    e_integ = lim(v.integ, 1, 65535);
    e_xfer  = lim(v.xfer, 1, 50);
    e_rowt  = lim(v.rowt, 12, 40);
    e_rows  = lim(v.rows, 1, 4095);
    e_pix   = lim(v.pix, 1, 4095);
    e_clamp = (e_pix < 28) ? e_pix : 28;
    shut_t = 16'(v.shut); integ_t = 16'(v.integ); xfer_t = 16'(v.xfer);
    rowt_t = 16'(v.rowt); rows = 12'(v.rows); pix = 12'(v.pix); byp = v.byp[0];
    @(negedge clk); clear_mon();
    start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (n_done == 0 && t < 5000) begin
      @(negedge clk); t++;
      start = (mid_start && t == 10);
      if (mid_cfg && t == 5) begin pix = 5; rows = 1; byp = ~byp; end
    end
    repeat (3) @(negedge clk);
    chk("R10 frame completes", (t < 5000) ? 1 : 0, 1);
    chk("R1 shutter width", n_shut, v.exp_shut);
    chk("R3 integration gap", v1_first - shut_fall, e_integ);
    chk("R4 transfer width", n_v1, e_xfer);
    chk("R4 row follows transfer", vs_first - v1_first, e_xfer);
    chk("R5 row shift total", n_vs, e_rows * e_rowt);
    chk("R6 line count", n_lines, v.exp_lines);
    chk("R6 horizontal total", n_h, e_rows * e_pix);
    chk("R7 clamp total", n_clamp, e_rows * e_clamp);
    chk("R8 reset-gate pulses", n_rg, e_rows);
    chk("R9 multiplier total", n_mult, v.byp ? 0 : e_rows * e_pix);
    chk("R10 done single", n_done, 1);
    chk("R10 done timing", done_at - last_h, 1);
    chk("R10 busy held", busy_low, 0);
    chk("R2 R5 R6 R7 R8 stop/park/window violations", viol, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R11 reset park", int'({shutter, v1, vshift, h_run, h1, h2, mult, clamp, rg, busy, done}),
        int'(11'b00001000000));
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle without start", int'({shutter, busy, h_run}), 0);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], 0, 0);

    // R11: second start inside frame ignored
    run_frame(VECS[0], 1, 0);
    // R11: config changed mid-frame ignored
    run_frame(VECS[0], 0, 1);

    // R11: reset mid-frame parks outputs
    shut_t = 16'd30; rows = 12'd2; pix = 12'd40; byp = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (60) @(negedge clk);
    rst_n = 0;
    #1;
    chk("R11 async reset park", int'({shutter, v1, vshift, h_run, h1, h2, mult, clamp, rg, busy, done}),
        int'(11'b00001000000));
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R11 stays idle after reset", int'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule